// File: doc/BRIEF.md
# Stop-Mode Entry and Wakeup Sequencer

This block decides when a deep-sleep stop request from the processor may take effect, drives the power-domain controls for the selected stop flavour, and times the wakeup. A stop request only counts when the deep-sleep flag and the stop request are both high. Entry is held off while a flash program operation or a peripheral-bus transfer is still in flight. While entry is held off, a wakeup event cancels it.

Four configuration bits choose the flavour: regulator low-power, flash power-down, main-regulator low-voltage and low-power-regulator low-voltage. They are captured at the moment of entry. On wakeup, one down-counter runs through three delay terms in turn: oscillator startup, flash wakeup and regulator wakeup. Each term is used only when the captured flavour needs it. A one-cycle ready pulse marks the end of the wakeup latency. A separate input states that flash was left in its own low-power state while code runs from on-chip SRAM. When it is set, the flash term is skipped.

Top module: `stop_seq`

## Requirements
- R1: Stop is entered only when `deep_req` and `stop_req` are both high at a clock edge. Either one alone leaves `stop_active` low.
- R2: When `flash_busy` or `bus_busy` is high, entry waits. `stop_active` rises one cycle after the edge at which the request is present and both busy flags are low.
- R3: While stopped, the outputs follow the captured configuration. `reg_lp` equals `cfg_lp`. `reg_lv` equals `cfg_lp_lv` when `cfg_lp`=1, and `cfg_mr_lv` when `cfg_lp`=0. `flash_pd` equals `cfg_fpd` OR `reg_lv`. When not stopped, all three are 0.
- R4: The configuration bits and `flash_keep` are captured at entry. Changing them while stopped alters neither the outputs nor the wakeup latency.
- R5: A wakeup sampled in stop makes `ready` go high exactly L cycles later, for exactly one cycle. L is T_OSC, plus T_FLASH if flash was powered down, plus a regulator term. The regulator term is T_LPLV for low-power low-voltage, T_MRLV for main low-voltage, T_REG for low-power regulator without low-voltage, and 0 otherwise.
- R6: A wakeup that arrives while entry is held off returns the block to run mode, with no `stop_active` and no `ready`. This holds even in the cycle in which the busy flags clear.
- R7: A wakeup sampled in run mode has no effect: `ready` stays low.
- R8: When `flash_keep` was high at entry, the flash term is left out of L. The regulator term still applies.
- R9: A low-voltage bit that belongs to the regulator not selected by `cfg_lp` is ignored. It affects neither the outputs nor L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| deep_req | input | 1 | Processor deep-sleep flag |
| stop_req | input | 1 | Processor sleep/stop request |
| cfg_lp | input | 1 | Use low-power regulator in stop |
| cfg_fpd | input | 1 | Power down flash in stop |
| cfg_mr_lv | input | 1 | Main regulator low-voltage in stop |
| cfg_lp_lv | input | 1 | Low-power regulator low-voltage in stop |
| flash_keep | input | 1 | Flash left in low power on wakeup (SRAM execution) |
| flash_busy | input | 1 | Flash program operation in progress |
| bus_busy | input | 1 | Peripheral-bus transfer in progress |
| wake | input | 1 | Wakeup event |
| stop_active | output | 1 | Stop mode in effect |
| reg_lp | output | 1 | Regulator in low-power mode |
| reg_lv | output | 1 | Regulator in low-voltage mode |
| flash_pd | output | 1 | Flash powered down |
| ready | output | 1 | One-cycle pulse at end of wakeup latency |

## Verification
Entry cancellation and entry release can fall in the same cycle. This happens when a wakeup arrives in the very cycle that the last busy flag drops while entry is pending. The bench provokes it by clearing `flash_busy` and raising `wake` at the same clock edge. It then judges that the block never shows `stop_active` and never pulses `ready`, because the cancellation must win. Wakeup latencies are judged by a scoreboard that counts cycles from the sampled wakeup to the ready pulse, for every stop flavour.

// File: rtl/stop_seq.sv
module stop_seq #(
  parameter int T_OSC   = 4,
  parameter int T_FLASH = 6,
  parameter int T_REG   = 5,
  parameter int T_MRLV  = 7,
  parameter int T_LPLV  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic deep_req,
  input  logic stop_req,
  input  logic cfg_lp,
  input  logic cfg_fpd,
  input  logic cfg_mr_lv,
  input  logic cfg_lp_lv,
  input  logic flash_keep,
  input  logic flash_busy,
  input  logic bus_busy,
  input  logic wake,
  output logic stop_active,
  output logic reg_lp,
  output logic reg_lv,
  output logic flash_pd,
  output logic ready
);
  localparam int M1   = (T_OSC > T_FLASH) ? T_OSC : T_FLASH;
  localparam int M2   = (T_REG > T_MRLV) ? T_REG : T_MRLV;
  localparam int M3   = (M2 > T_LPLV) ? M2 : T_LPLV;
  localparam int MAXT = (M1 > M3) ? M1 : M3;
  localparam int CW   = (MAXT > 1) ? $clog2(MAXT) : 1;

  typedef enum logic [2:0] {S_RUN, S_PEND, S_STOP, S_OSC, S_FLASH, S_REG} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic m_lp, m_lv, m_fpd, m_keep;

  wire go     = deep_req & stop_req;
  wire idle   = ~flash_busy & ~bus_busy;
  wire c_lv   = cfg_lp ? cfg_lp_lv : cfg_mr_lv;
  wire need_f = m_fpd & ~m_keep;
  wire need_r = m_lp | m_lv;
  wire [CW-1:0] reg_len = m_lv ? (m_lp ? CW'(T_LPLV - 1) : CW'(T_MRLV - 1)) : CW'(T_REG - 1);

  assign stop_active = (st == S_STOP);
  assign reg_lp      = stop_active & m_lp;
  assign reg_lv      = stop_active & m_lv;
  assign flash_pd    = stop_active & m_fpd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RUN; cnt <= '0; ready <= 1'b0;
      m_lp <= 1'b0; m_lv <= 1'b0; m_fpd <= 1'b0; m_keep <= 1'b0;
    end else begin
      ready <= 1'b0;
      case (st)
        S_RUN, S_PEND: begin
          if (st == S_PEND && wake) st <= S_RUN;
          else if ((go || st == S_PEND) && idle) begin
            st     <= S_STOP;
            m_lp   <= cfg_lp;
            m_lv   <= c_lv;
            m_fpd  <= cfg_fpd | c_lv;
            m_keep <= flash_keep;
          end else if (go) st <= S_PEND;
        end
        S_STOP: if (wake) begin st <= S_OSC; cnt <= CW'(T_OSC - 1); end
        S_OSC:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (need_f) begin st <= S_FLASH; cnt <= CW'(T_FLASH - 1); end
          else if (need_r) begin st <= S_REG; cnt <= reg_len; end
          else begin st <= S_RUN; ready <= 1'b1; end
        S_FLASH:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (need_r) begin st <= S_REG; cnt <= reg_len; end
          else begin st <= S_RUN; ready <= 1'b1; end
        S_REG:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin st <= S_RUN; ready <= 1'b1; end
        default: st <= S_RUN;
      endcase
    end
  end

  p_entry_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !go) |=> !stop_active);
  p_busy_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_active && (flash_busy || bus_busy)) |=> !stop_active);
  p_idle_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_active |-> (!reg_lp && !reg_lv && !flash_pd));
  p_lv_implies_pd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_lv |-> flash_pd);
  p_cfg_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_active && $past(stop_active)) |-> $stable({reg_lp, reg_lv, flash_pd}));
  p_ready_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  p_ready_after_wakeup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(st) == S_OSC || $past(st) == S_FLASH || $past(st) == S_REG));
  p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PEND && wake) |=> (st == S_RUN && !ready && !stop_active));
endmodule

// File: tb/test_stop_seq.sv
module test_stop_seq;
  localparam int T_OSC = 4, T_FLASH = 6, T_REG = 5, T_MRLV = 7, T_LPLV = 8;

  logic clk = 0, rst_n = 0;
  logic deep_req = 0, stop_req = 0, cfg_lp = 0, cfg_fpd = 0, cfg_mr_lv = 0, cfg_lp_lv = 0;
  logic flash_keep = 0, flash_busy = 0, bus_busy = 0, wake = 0;
  logic stop_active, reg_lp, reg_lv, flash_pd, ready;

  int tests = 0, fails = 0;
  int expq[$];
  int cnt = 0;
  bit counting = 0;
  bit done = 0;

  always #10 clk = ~clk;

  stop_seq #(.T_OSC(T_OSC), .T_FLASH(T_FLASH), .T_REG(T_REG), .T_MRLV(T_MRLV), .T_LPLV(T_LPLV))
    i_stop_seq (.*);

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lat(input bit lp, fpd, mrlv, lplv, keep);
    bit lv = lp ? lplv : mrlv;
    int l = T_OSC;
    if ((fpd || lv) && !keep) l += T_FLASH;
    if (lp && lv) l += T_LPLV;
    else if (lv) l += T_MRLV;
    else if (lp) l += T_REG;
    return l;
  endfunction

  // monitor: measures wake-to-ready and pops expected latency
  always @(negedge clk) begin
    if (counting) begin
      if (ready) begin
        counting = 0;
        if (expq.size() == 0) chk("R5 unexpected ready", 1, 0);
        else chk("R5 latency", cnt, expq.pop_front());
      end else cnt++;
    end else if (ready) chk("R6/R7 stray ready", 1, 0);
    if (!counting && wake && stop_active) begin counting = 1; cnt = 0; end
  end

  task automatic stop_cycle(input bit lp, fpd, mrlv, lplv, keep, input string tag);
    bit lv = lp ? lplv : mrlv;
    @(negedge clk);
    {cfg_lp, cfg_fpd, cfg_mr_lv, cfg_lp_lv, flash_keep} = {lp, fpd, mrlv, lplv, keep};
    deep_req = 1; stop_req = 1;
    @(negedge clk);
    deep_req = 0; stop_req = 0;
    chk({tag, " R1 stop entered"}, stop_active, 1);
    chk({tag, " R3 reg_lp"}, reg_lp, lp);
    chk({tag, " R3/R9 reg_lv"}, reg_lv, lv);
    chk({tag, " R3 flash_pd"}, flash_pd, fpd | lv);
    {cfg_lp, cfg_fpd, cfg_mr_lv, cfg_lp_lv, flash_keep} = ~{lp, fpd, mrlv, lplv, keep};
    repeat (2) @(negedge clk);
    chk({tag, " R4 outputs held"}, {reg_lp, reg_lv, flash_pd}, {lp, lv, fpd | lv});
    expq.push_back(lat(lp, fpd, mrlv, lplv, keep));
    wake = 1;
    @(negedge clk);
    wake = 0;
    chk({tag, " R5 stop released"}, stop_active, 0);
    while (counting) @(negedge clk);
    @(negedge clk);
    chk({tag, " R5 ready one cycle"}, ready, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R3 reset stop_active", stop_active, 0);
    chk("R3 reset outputs", {reg_lp, reg_lv, flash_pd, ready}, 0);
    rst_n = 1;
    @(negedge clk);

    deep_req = 1; repeat (3) @(negedge clk);
    chk("R1 deep only", stop_active, 0);
    deep_req = 0; stop_req = 1; repeat (3) @(negedge clk);
    chk("R1 stop only", stop_active, 0);
    stop_req = 0;

    wake = 1; @(negedge clk); wake = 0; repeat (3) @(negedge clk);
    chk("R7 wake in run", ready, 0);

    stop_cycle(0, 0, 0, 0, 0, "main");
    stop_cycle(0, 1, 0, 0, 0, "main+fpd");
    stop_cycle(1, 0, 0, 0, 0, "lp");
    stop_cycle(1, 1, 0, 0, 0, "lp+fpd");
    stop_cycle(0, 0, 1, 0, 0, "mrlv");
    stop_cycle(1, 0, 0, 1, 0, "lplv");
    stop_cycle(0, 1, 0, 0, 1, "R8 keep main");
    stop_cycle(1, 0, 0, 1, 1, "R8 keep lplv");
    stop_cycle(0, 0, 0, 1, 0, "R9 lplv unused");
    stop_cycle(1, 0, 1, 0, 0, "R9 mrlv unused");

    // R2: busy flags delay entry
    @(negedge clk);
    {cfg_lp, cfg_fpd, cfg_mr_lv, cfg_lp_lv, flash_keep} = 5'b01000;
    flash_busy = 1; bus_busy = 1; deep_req = 1; stop_req = 1;
    repeat (3) @(negedge clk);
    chk("R2 held by both", stop_active, 0);
    flash_busy = 0; repeat (2) @(negedge clk);
    chk("R2 held by bus", stop_active, 0);
    bus_busy = 0; @(negedge clk);
    deep_req = 0; stop_req = 0;
    chk("R2 entry after release", stop_active, 1);
    expq.push_back(lat(0, 1, 0, 0, 0));
    wake = 1; @(negedge clk); wake = 0;
    while (counting) @(negedge clk);

    // R6: cancel while pending
    @(negedge clk);
    bus_busy = 1; deep_req = 1; stop_req = 1;
    repeat (2) @(negedge clk);
    wake = 1; deep_req = 0; stop_req = 0;
    @(negedge clk); wake = 0; bus_busy = 0;
    repeat (4) @(negedge clk);
    chk("R6 cancel while busy", stop_active, 0);

    // R6: wake in same cycle as busy release
    flash_busy = 1; deep_req = 1; stop_req = 1;
    repeat (2) @(negedge clk);
    flash_busy = 0; wake = 1; deep_req = 0; stop_req = 0;
    @(negedge clk); wake = 0;
    chk("R6 wake beats release", stop_active, 0);
    repeat (T_OSC + T_FLASH + T_LPLV + 2) @(negedge clk);
    chk("R6 no stop after cancel", stop_active, 0);
    chk("R5 queue drained", expq.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule